// File: doc/BRIEF.md
# Descriptor Queue Manager with Pending Bitmap

This block is a bank of small hardware FIFOs that hold descriptor pointers for a DMA engine. Each queue is reached through one register address. A write to that address pushes a word, and a read from it pops the oldest word. A pushed word is a 32-byte-aligned descriptor address. Its low five bits carry a descriptor size code, and the queue stores that code unchanged with the address. Software recovers the address by clearing bits 4:0.

Every queue has a pending bit that is set while the queue holds at least one entry. The pending bits are read as 32-bit bitmap words. An interrupt output marks completion work. A programmable first-completion index splits the queues into two groups: only queues at or above that index drive the interrupt, and submit queues below it never do. A push to a full queue is discarded and raises a sticky overflow flag.

The register port has separate write and read addresses, so a push and a pop can fall in the same cycle. Read data appears one clock after the read strobe.

Top module: `desc_queue_mgr`

## Requirements
- R1: A write to address q, with q below 160, appends the 32-bit word to queue q. A read of address q returns that queue's oldest word on rdData one cycle later and removes it, so words come out in push order. The word is returned bit for bit, including a size code such as 2 in bits 4:0.
- R2: A read of an empty queue's address returns zero and leaves the queue empty.
- R3: A read of address 0x100+w, with w from 0 to 4, returns pending word w. Bit b of that word is 1 exactly when queue 32*w+b holds at least one entry.
- R4: irq is 1 exactly when some non-empty queue has an index greater than or equal to the first-completion index. Non-empty queues below that index, including those in the same bitmap word, leave irq at 0.
- R5: The first-completion index is a register at address 0x180. It resets to 93. A write loads it from wrData[7:0], and a read of 0x180 returns it zero-extended.
- R6: Each queue holds 4 entries. A push to a full queue that is not popped in the same cycle is discarded and leaves the contents unchanged. It sets overflow, which then stays 1 until reset.
- R7: A push and a pop to the same queue in one cycle both take effect. The pop sees the queue as it was before the cycle. An empty queue returns zero and keeps the pushed word. A full queue accepts the push without setting overflow.
- R8: irq is a level. It stays 1 over idle cycles while a qualifying entry remains, and it drops in the cycle after the last qualifying entry is popped.
- R9: Writes to addresses that are not a queue and not 0x180 change nothing, including writes to the pending words and to queue numbers of 160 and above. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 9 | Write address |
| wrData | input | 32 | Write data (descriptor word or index) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 9 | Read address |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| irq | output | 1 | Level interrupt for qualifying pending queues |
| overflow | output | 1 | Sticky flag for a discarded push |

## Verification
A wrong occupancy count or pointer shows at the ports within one read. A pop returns a word out of order, a stale word, or zero where data was expected, and the matching pending bit disagrees in the very next bitmap read. A wrong comparison against the first-completion index shows on irq in the cycle right after the push, pop or index write that crosses the boundary. A missed drop shows as a surplus word or a clear overflow flag on the next drain of the full queue.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 9;
  localparam int QIDX_W     = 8;
  localparam int PEND_IDX_W = 3;
  localparam logic [ADDR_W-1:0] PEND_BASE = 9'h100;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 9'h180;

  typedef struct packed {
    logic                  push;
    logic [QIDX_W-1:0]     pushQ;
    logic [DATA_W-1:0]     pushData;
    logic                  pop;
    logic [QIDX_W-1:0]     popQ;
    logic                  pendRd;
    logic [PEND_IDX_W-1:0] pendW;
    logic                  cfgRd;
    logic                  anyRd;
  } qmStrobe_t;
endpackage

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES       = 160,
  parameter int FIRST_COMP_RESET = 93
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output qmStrobe_t         st,
  output logic [QIDX_W-1:0] firstComp
);
  localparam int NUM_WORDS = (NUM_QUEUES + 31) / 32;
  localparam logic [ADDR_W-1:0] QUEUE_LIMIT = ADDR_W'(NUM_QUEUES);
  localparam logic [ADDR_W-1:0] PEND_LIMIT  = PEND_BASE + ADDR_W'(NUM_WORDS);

  logic cfgWr;

  always_comb begin
    st          = '0;
    st.push     = wrEn && (wrAddr < QUEUE_LIMIT);
    st.pushQ    = wrAddr[QIDX_W-1:0];
    st.pushData = wrData;
    st.pop      = rdEn && (rdAddr < QUEUE_LIMIT);
    st.popQ     = rdAddr[QIDX_W-1:0];
    st.pendRd   = rdEn && (rdAddr >= PEND_BASE) && (rdAddr < PEND_LIMIT);
    st.pendW    = rdAddr[PEND_IDX_W-1:0];
    st.cfgRd    = rdEn && (rdAddr == CFG_ADDR);
    st.anyRd    = rdEn;
    cfgWr       = wrEn && (wrAddr == CFG_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) firstComp <= QIDX_W'(FIRST_COMP_RESET);
    else if (cfgWr) firstComp <= wrData[QIDX_W-1:0];
  end

  // R9: only the index address may change the first-completion index
  assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != CFG_ADDR) |=> $stable(firstComp));
endmodule

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES  = 160,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  qmStrobe_t         st,
  input  logic [QIDX_W-1:0] firstComp,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              overflow
);
  localparam int PTR_W     = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W     = $clog2(QUEUE_DEPTH + 1);
  localparam int NUM_WORDS = (NUM_QUEUES + 31) / 32;
  localparam int PEND_BITS = NUM_WORDS * 32;

  logic [DATA_W-1:0] store [NUM_QUEUES][QUEUE_DEPTH];
  logic [CNT_W-1:0]  cnt [NUM_QUEUES];
  logic [PTR_W-1:0]  headPtr [NUM_QUEUES];
  logic [PTR_W-1:0]  tailPtr [NUM_QUEUES];
  logic [PEND_BITS-1:0]  pendVec;
  logic [NUM_QUEUES-1:0] qualVec;
  logic popHasData, popEmpty, pushOk, pushDrop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_pend
    assign pendVec[q] = (cnt[q] != '0);
    assign qualVec[q] = pendVec[q] && (QIDX_W'(q) >= firstComp);
  end
  if (PEND_BITS > NUM_QUEUES) begin : g_pad
    assign pendVec[PEND_BITS-1:NUM_QUEUES] = '0;
  end

  assign irq        = |qualVec;
  assign popHasData = st.pop && (cnt[st.popQ] != '0);
  assign popEmpty   = st.pop && (cnt[st.popQ] == '0);
  assign pushOk     = st.push && ((cnt[st.pushQ] != CNT_W'(QUEUE_DEPTH)) ||
                                  (popHasData && st.popQ == st.pushQ));
  assign pushDrop   = st.push && !pushOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        cnt[q]     <= '0;
        headPtr[q] <= '0;
        tailPtr[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        case ({pushOk && st.pushQ == QIDX_W'(q), popHasData && st.popQ == QIDX_W'(q)})
          2'b10:   cnt[q] <= cnt[q] + 1'b1;
          2'b01:   cnt[q] <= cnt[q] - 1'b1;
          default: cnt[q] <= cnt[q];
        endcase
      end
      if (pushOk)     tailPtr[st.pushQ] <= nextPtr(tailPtr[st.pushQ]);
      if (popHasData) headPtr[st.popQ]  <= nextPtr(headPtr[st.popQ]);
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) store[st.pushQ][tailPtr[st.pushQ]] <= st.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (st.anyRd) begin
      if (popHasData)    rdData <= store[st.popQ][headPtr[st.popQ]];
      else if (st.pendRd) rdData <= pendVec[st.pendW*32 +: 32];
      else if (st.cfgRd)  rdData <= DATA_W'(firstComp);
      else               rdData <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else if (pushDrop) overflow <= 1'b1;
  end

  assert_empty_pop_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    popEmpty |=> (rdData == '0));
  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    pushDrop |=> overflow);
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.push |-> (cnt[st.pushQ] <= CNT_W'(QUEUE_DEPTH)));
  // R7: a same-queue pop of a non-empty queue always makes room for the push
  assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.push && popHasData && st.popQ == st.pushQ) |-> !pushDrop);
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES       = 160,
  parameter int QUEUE_DEPTH      = 4,
  parameter int FIRST_COMP_RESET = 93
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              overflow
);
  qmStrobe_t         st;
  logic [QIDX_W-1:0] firstComp;

  qm_ctrl #(.NUM_QUEUES(NUM_QUEUES), .FIRST_COMP_RESET(FIRST_COMP_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .st(st), .firstComp(firstComp));

  qm_datapath #(.NUM_QUEUES(NUM_QUEUES), .QUEUE_DEPTH(QUEUE_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .firstComp(firstComp),
    .rdData(rdData), .irq(irq), .overflow(overflow));
endmodule

// File: tb/sim_desc_queue_mgr.sv
module sim_desc_queue_mgr;
  localparam int NQ = 160;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [8:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq, overflow;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] mq [NQ][$];
  int mFirst = 93;
  bit mOvf = 0;

  always #10 clk = ~clk;

  desc_queue_mgr u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .irq(irq), .overflow(overflow));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pendWord(input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (32*w + b < NQ && mq[32*w+b].size() > 0) v[b] = 1'b1;
    return v;
  endfunction

  function automatic logic expIrq();
    for (int q = 0; q < NQ; q++)
      if (q >= mFirst && mq[q].size() > 0) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: optional write and read, then model update and checks
  task automatic op(input string tag, input bit we, input int wa, input logic [31:0] wd,
                    input bit re, input int ra);
    logic [31:0] expRd = '0;
    @(negedge clk);
    wrEn = we; wrAddr = 9'(wa); wrData = wd;
    rdEn = re; rdAddr = 9'(ra);
    if (re) begin
      if (ra < NQ) expRd = (mq[ra].size() > 0) ? mq[ra].pop_front() : 32'h0;
      else if (ra >= 256 && ra < 261) expRd = pendWord(ra - 256);
      else if (ra == 384) expRd = 32'(mFirst);
      else expRd = 32'h0;
    end
    if (we) begin
      if (wa < NQ) begin
        if (mq[wa].size() < DEPTH) mq[wa].push_back(wd);
        else mOvf = 1;
      end else if (wa == 384) mFirst = int'(wd[7:0]);
    end
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    if (re) chk({tag, " rdData"}, rdData, expRd);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, expIrq()});
    chk({tag, " overflow"}, {31'b0, overflow}, {31'b0, mOvf});
  endtask

  task automatic push(input string tag, input int q, input logic [31:0] d);
    op(tag, 1, q, d, 0, 0);
  endtask
  task automatic pop(input string tag, input int q);
    op(tag, 0, 0, 0, 1, q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset irq", {31'b0, irq}, 32'h0);
    chk("reset overflow", {31'b0, overflow}, 32'h0);
    op("R5 reset index", 0, 0, 0, 1, 384);
    for (int w = 0; w < 5; w++) op("R3 reset pending", 0, 0, 0, 1, 256 + w);

    // R1 order and size code kept
    push("R1 push a", 5, 32'h0000_1002);
    push("R1 push b", 5, 32'h0000_1022);
    pop("R1 pop a", 5);
    pop("R1 pop b", 5);
    pop("R2 empty pop", 5);
    pop("R2 still empty", 5);

    // R3 bitmap position
    push("R3 q33", 33, 32'h0000_2002);
    push("R3 q159", 159, 32'h0000_3002);
    op("R3 word1", 0, 0, 0, 1, 257);
    op("R3 word4", 0, 0, 0, 1, 260);
    pop("R3 drain 33", 33);
    op("R3 word1 clear", 0, 0, 0, 1, 257);

    // R4 only queues at or above the index count (q159 still pending)
    pop("R4 drain 159", 159);
    push("R4 q92 below", 92, 32'h0000_4002);
    op("R3 word2", 0, 0, 0, 1, 258);
    push("R4 q93 at index", 93, 32'h0000_5002);
    op("R8 idle 1", 0, 0, 0, 0, 0);
    op("R8 idle 2", 0, 0, 0, 0, 0);
    pop("R8 drop after pop", 93);

    // R5 programmable index
    op("R5 lower index", 1, 384, 32'd40, 0, 0);
    op("R5 read index", 0, 0, 0, 1, 384);
    op("R5 restore index", 1, 384, 32'd93, 0, 0);
    pop("R4 drain 92", 92);

    // R9 ignored writes and unmapped reads
    push("R9 write pending word", 256, 32'hFFFF_FFFF);
    op("R9 pending word0 unchanged", 0, 0, 0, 1, 256);
    push("R9 write queue 200", 200, 32'h0000_6002);
    op("R9 read queue 200", 0, 0, 0, 1, 200);
    op("R9 read unmapped", 0, 0, 0, 1, 300);
    op("R9 index unchanged", 0, 0, 0, 1, 384);

    // R7 same-cycle push and pop
    op("R7 empty push+pop", 1, 8, 32'h0000_0AA2, 1, 8);
    pop("R7 pushed word kept", 8);
    for (int i = 0; i < DEPTH; i++) push("R7 fill", 9, 32'h0000_9002 + 32'(i) * 32);
    op("R7 full push+pop", 1, 9, 32'h0000_9F02, 1, 9);
    for (int i = 0; i < DEPTH; i++) pop("R7 drain", 9);

    // R6 overflow
    for (int i = 0; i < DEPTH + 1; i++) push("R6 fill", 7, 32'h0000_7002 + 32'(i) * 32);
    for (int i = 0; i < DEPTH + 1; i++) pop("R6 drain", 7);
    op("R6 sticky", 0, 0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int qs [8] = '{0, 31, 32, 92, 93, 94, 159, 40};
      int qw, qr, kind;
      bit we, re;
      qw = qs[$urandom_range(7)];
      qr = ($urandom_range(3) == 0) ? qw : qs[$urandom_range(7)];
      kind = $urandom_range(19);
      we = ($urandom_range(1) == 1);
      re = ($urandom_range(1) == 1);
      if (kind == 0) op("R5 random index", 1, 384, 32'($urandom_range(1) ? 93 : 40), re, qr);
      else if (kind == 1) op("R3 random pending", we, qw, {$urandom_range(255), 5'd2}, 1, 256 + $urandom_range(4));
      else op("R1 random", we, qw, {$urandom_range(32'h7FFFF), 5'd2}, re, qr);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule